// File: doc/BRIEF.md
# Triggered ADC Integration Window Sequencer

This block sits in the fast trigger clock domain of a digitizer and produces three things: a sample strobe, an integration window, and a pair of per-sample marker bits. The strobe comes from a free-running divide-by-DIV counter (17 by default). A sync pulse, normally sent once at the start of a run, forces every module's divider to the same phase so that all modules sample together.

A trigger arms the sequencer. The window opens at the next sample strobe and then runs for a configurable number of blocks, each holding a configurable number of samples. Busy stays high from the acceptance of the trigger until the window closes, and the trigger interface uses it to hold off further triggers.

Each sample is tagged with two markers. One says the sample lies inside the window. The other gives the parity of the subblock the sample belongs to. The datapath registers the markers beside the sample at the same strobe edge.

Top module: `adcwin_seq`

## Requirements
- R1: `strobe_o` is high for exactly one clock cycle in every DIV cycles while `sync_i` stays low.
- R2: When `sync_i` is high at a clock edge, the divider restarts. `strobe_o` is low in the following cycle and first goes high in the DIVth cycle after that edge. Leaving reset gives the same phase.
- R3: A `trig_i` that is high at a clock edge while `busy_o` is low and `sync_i` is low is accepted, and `busy_o` is high from the next cycle.
- R4: The window opens at the first strobe edge after acceptance. A strobe in the same cycle as the accepted trigger does not count. `mark_win_o` and `mark_par_o` change only at strobe edges, or at a sync edge.
- R5: The markers loaded at a strobe edge belong to the sample taken at that strobe. `mark_win_o` is 1 for exactly B×S consecutive samples, where B is the latched block count and S is the latched samples-per-block count.
- R6: `mark_par_o` is 0 for the first S samples of a window and inverts after every S samples.
- R7: A configured block count or sample count of 0 behaves as 1.
- R8: Both counts are latched at the edge that opens the window. Changes to the configuration inputs during a window have no effect on that window.
- R9: At the strobe edge after the last window sample, `busy_o`, `mark_win_o` and `mark_par_o` all fall to 0 together.
- R10: A trigger that arrives while `busy_o` is high is ignored. No further window opens without a new trigger.
- R11: `sync_i` during a window aborts it. In the next cycle `busy_o`, `mark_win_o` and `mark_par_o` are 0, and the divider phase restarts as described in R2.
- R12: While reset is held, and in the first cycle after it, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Trigger-domain clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sync_i | input | 1 | Divider phase restart; aborts a window |
| trig_i | input | 1 | Trigger pulse |
| cfg_blocks_i | input | BLK_W | Blocks per window (0 acts as 1) |
| cfg_samples_i | input | SMP_W | Samples per block (0 acts as 1) |
| strobe_o | output | 1 | Sample strobe, one cycle every DIV |
| busy_o | output | 1 | High from trigger acceptance to window close |
| mark_win_o | output | 1 | Tag of the current sample: inside the window |
| mark_par_o | output | 1 | Tag of the current sample: odd subblock |

## Verification
The bench builds the block with DIV=17 and both count widths set to 3. With those widths the random draws of 0 to 7 cover the zero value, which behaves as one, and the all-ones limit of each counter. Every window is still short enough to run several dozen windows, with sync aborts and triggers landing on strobe cycles, within the cycle budget. Keeping the divide ratio at 17 checks the real phase spacing against a per-cycle reference model.

// File: rtl/adcwin_pkg.sv
package adcwin_pkg;

   typedef struct packed {
      logic win;
      logic par;
   } adcwin_tag_t;

   typedef enum logic [1:0] {
      WS_IDLE  = 2'd0,
      WS_ARMED = 2'd1,
      WS_OPEN  = 2'd2
   } adcwin_state_t;

endpackage

// File: rtl/adcwin_strobe_div.sv
module adcwin_strobe_div #(
   parameter int DIV = 17
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sync_i,
   output logic strobe_o
);

   localparam int DW = (DIV > 1) ? $clog2(DIV) : 1;

   generate
      if (DIV < 1) begin : g_bad_div
         $error("adcwin_strobe_div: DIV must be at least 1");
      end

      if (DIV == 1) begin : g_passthru
         assign strobe_o = 1'b1;
      end else begin : g_counter
         logic [DW-1:0] ph_q;

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               ph_q <= '0;
            end else if (sync_i) begin
               ph_q <= '0;
            end else if (ph_q == DW'(DIV - 1)) begin
               ph_q <= '0;
            end else begin
               ph_q <= ph_q + DW'(1);
            end
         end

         assign strobe_o = (ph_q == DW'(DIV - 1));

         AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
            strobe_o |=> !strobe_o); // R1

         AST_SYNC_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
            sync_i |=> !strobe_o); // R2
      end
   endgenerate

endmodule

// File: rtl/adcwin_wrap_cnt.sv
module adcwin_wrap_cnt #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr_i,
   input  logic         en_i,
   input  logic [W-1:0] lim_i,
   output logic [W-1:0] q_o,
   output logic         last_o
);

   generate
      if (W < 1) begin : g_bad_w
         $error("adcwin_wrap_cnt: W must be at least 1");
      end
   endgenerate

   logic [W-1:0] q_q;

   assign last_o = (q_q == lim_i - W'(1));
   assign q_o    = q_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         q_q <= '0;
      end else if (clr_i) begin
         q_q <= '0;
      end else if (en_i) begin
         q_q <= last_o ? '0 : q_q + W'(1);
      end
   end

   AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      en_i |-> (q_q < lim_i)); // R5

endmodule

// File: rtl/adcwin_window_ctl.sv
module adcwin_window_ctl
   import adcwin_pkg::*;
#(
   parameter int BLK_W = 8,
   parameter int SMP_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sync_i,
   input  logic             strobe_i,
   input  logic             trig_i,
   input  logic [BLK_W-1:0] cfg_blk_i,
   input  logic [SMP_W-1:0] cfg_smp_i,
   output logic             busy_o,
   output adcwin_tag_t      tag_o
);

   generate
      if (BLK_W < 1 || SMP_W < 1) begin : g_bad_w
         $error("adcwin_window_ctl: count widths must be at least 1");
      end
   endgenerate

   adcwin_state_t    st_q;
   logic             par_q;
   logic [BLK_W-1:0] blk_lim_q;
   logic [SMP_W-1:0] smp_lim_q;

   logic             open_w;
   logic             start_w;
   logic             smp_en_w;
   logic             smp_last_w;
   logic             blk_en_w;
   logic             blk_last_w;
   logic             cnt_clr_w;
   logic             close_w;
   logic [BLK_W-1:0] blk_q_w;
   logic [SMP_W-1:0] smp_q_w;

   assign open_w    = (st_q == WS_OPEN);
   assign start_w   = strobe_i && (st_q == WS_ARMED) && !sync_i;
   assign smp_en_w  = strobe_i && open_w && !sync_i;
   assign blk_en_w  = smp_en_w && smp_last_w;
   assign close_w   = blk_en_w && blk_last_w;
   assign cnt_clr_w = sync_i || start_w;

   adcwin_wrap_cnt #(.W(SMP_W)) u_smp_cnt (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr_i  (cnt_clr_w),
      .en_i   (smp_en_w),
      .lim_i  (smp_lim_q),
      .q_o    (smp_q_w),
      .last_o (smp_last_w)
   );

   adcwin_wrap_cnt #(.W(BLK_W)) u_blk_cnt (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr_i  (cnt_clr_w),
      .en_i   (blk_en_w),
      .lim_i  (blk_lim_q),
      .q_o    (blk_q_w),
      .last_o (blk_last_w)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q      <= WS_IDLE;
         par_q     <= 1'b0;
         blk_lim_q <= BLK_W'(1);
         smp_lim_q <= SMP_W'(1);
      end else if (sync_i) begin
         st_q  <= WS_IDLE;
         par_q <= 1'b0;
      end else begin
         case (st_q)
            WS_IDLE: begin
               if (trig_i) st_q <= WS_ARMED;
            end
            WS_ARMED: begin
               if (strobe_i) begin
                  st_q      <= WS_OPEN;
                  par_q     <= 1'b0;
                  blk_lim_q <= (cfg_blk_i == '0) ? BLK_W'(1) : cfg_blk_i;
                  smp_lim_q <= (cfg_smp_i == '0) ? SMP_W'(1) : cfg_smp_i;
               end
            end
            WS_OPEN: begin
               if (close_w) begin
                  st_q  <= WS_IDLE;
                  par_q <= 1'b0;
               end else if (blk_en_w) begin
                  par_q <= ~par_q;
               end
            end
            default: begin
               st_q  <= WS_IDLE;
               par_q <= 1'b0;
            end
         endcase
      end
   end

   assign busy_o    = (st_q != WS_IDLE);
   assign tag_o.win = open_w;
   assign tag_o.par = par_q;

   AST_TRIG_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && trig_i && !sync_i) |=> busy_o); // R3

   AST_TAG_ON_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      (!strobe_i && !sync_i) |=> $stable(tag_o)); // R4

   AST_WIN_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      tag_o.win |-> busy_o); // R5

   AST_START_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tag_o.win) |-> !tag_o.par); // R6

   AST_PAR_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      !tag_o.win |-> !tag_o.par); // R9

   AST_SYNC_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
      sync_i |=> (!busy_o && !tag_o.win)); // R11

   AST_IDX_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      open_w |-> (blk_q_w < blk_lim_q && smp_q_w < smp_lim_q)); // R8

endmodule

// File: rtl/adcwin_seq.sv
module adcwin_seq
   import adcwin_pkg::*;
#(
   parameter int DIV   = 17,
   parameter int BLK_W = 8,
   parameter int SMP_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sync_i,
   input  logic             trig_i,
   input  logic [BLK_W-1:0] cfg_blocks_i,
   input  logic [SMP_W-1:0] cfg_samples_i,
   output logic             strobe_o,
   output logic             busy_o,
   output logic             mark_win_o,
   output logic             mark_par_o
);

   adcwin_tag_t tag_w;
   logic        strobe_w;

   adcwin_strobe_div #(.DIV(DIV)) u_div (
      .clk      (clk),
      .rst_n    (rst_n),
      .sync_i   (sync_i),
      .strobe_o (strobe_w)
   );

   adcwin_window_ctl #(.BLK_W(BLK_W), .SMP_W(SMP_W)) u_ctl (
      .clk       (clk),
      .rst_n     (rst_n),
      .sync_i    (sync_i),
      .strobe_i  (strobe_w),
      .trig_i    (trig_i),
      .cfg_blk_i (cfg_blocks_i),
      .cfg_smp_i (cfg_samples_i),
      .busy_o    (busy_o),
      .tag_o     (tag_w)
   );

   assign strobe_o   = strobe_w;
   assign mark_win_o = tag_w.win;
   assign mark_par_o = tag_w.par;

endmodule

// File: tb/sim_adcwin_seq.sv
`timescale 1ns/1ps
module sim_adcwin_seq;

   localparam int DIV = 17;
   localparam int BW  = 3;
   localparam int SW  = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          sync_i = 1'b0;
   logic          trig_i = 1'b0;
   logic [BW-1:0] cfg_b = '0;
   logic [SW-1:0] cfg_s = '0;
   logic          strobe_o, busy_o, mark_win_o, mark_par_o;

   int checks = 0;
   int errors = 0;
   int cyc = 0;

   always #2.5 clk = ~clk;

   adcwin_seq #(.DIV(DIV), .BLK_W(BW), .SMP_W(SW)) u0 (
      .clk(clk), .rst_n(rst_n), .sync_i(sync_i), .trig_i(trig_i),
      .cfg_blocks_i(cfg_b), .cfg_samples_i(cfg_s),
      .strobe_o(strobe_o), .busy_o(busy_o),
      .mark_win_o(mark_win_o), .mark_par_o(mark_par_o)
   );

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
      end
   endtask

   function automatic int fix1(input int v);
      return (v == 0) ? 1 : v;
   endfunction

   function automatic int exp_len(input int b, input int s);
      return fix1(b) * fix1(s);
   endfunction

   function automatic int exp_toggles(input int b);
      int bb;
      bb = fix1(b);
      return (bb - 1) + (((bb % 2) == 0) ? 1 : 0);
   endfunction

   // Reference model built from the requirements, advanced at each edge.
   int m_ph = 0;
   int m_k = 0, m_b = 1, m_s = 1;
   bit m_busy = 0, m_win = 0, m_par = 0;

   always @(posedge clk) begin
      cyc++;
      if (!rst_n) begin
         m_ph = 0; m_busy = 0; m_win = 0; m_par = 0; m_k = 0;
      end else if (sync_i) begin
         m_ph = 0; m_busy = 0; m_win = 0; m_par = 0;
      end else begin
         bit stb;
         stb = (m_ph == DIV - 1);
         m_ph = stb ? 0 : m_ph + 1;
         if (stb && m_win) begin
            m_k++;
            if (m_k == m_b * m_s) begin
               m_win = 0; m_par = 0; m_busy = 0;
            end else begin
               m_par = ((m_k / m_s) % 2) == 1;
            end
         end else if (stb && m_busy) begin
            m_b = fix1(int'(cfg_b)); m_s = fix1(int'(cfg_s));
            m_k = 0; m_win = 1; m_par = 0;
         end else if (!m_busy && trig_i) begin
            m_busy = 1;
         end
      end
   end

   always @(negedge clk) begin
      if (rst_n) begin
         chk("R1 strobe_o", int'(strobe_o), int'(m_ph == DIV - 1));
         chk("R3 busy_o", int'(busy_o), int'(m_busy));
         chk("R5 mark_win_o", int'(mark_win_o), int'(m_win));
         chk("R6 mark_par_o", int'(mark_par_o), int'(m_par));
      end
   end

   task automatic pulse_trig();
      @(negedge clk) trig_i = 1'b1;
      @(negedge clk) trig_i = 1'b0;
   endtask

   task automatic run_window(input int b, input int s, input bit mid_change,
                             input bit extra_trig);
      int n, tog;
      bit last_win, prev_par;
      cfg_b = BW'(b); cfg_s = SW'(s);
      pulse_trig();
      n = 0; tog = 0; last_win = 0; prev_par = 0;
      while (busy_o) begin
         if (strobe_o && mark_win_o) n++;
         if (mark_par_o != prev_par) tog++;
         prev_par = mark_par_o;
         if (mid_change && mark_win_o) begin
            cfg_b = '1; cfg_s = '1;
         end
         trig_i = extra_trig && strobe_o && mark_win_o && (n == 2);
         last_win = mark_win_o;
         @(negedge clk);
      end
      trig_i = 1'b0;
      if (mark_par_o != prev_par) tog++;
      chk("R9 close together", {30'd0, mark_win_o, last_win}, 1);
      chk("R9 par low at close", int'(mark_par_o), 0);
      if (mid_change) chk("R8 latched length", n, exp_len(b, s));
      else if (b == 0 || s == 0) chk("R7 zero as one", n, exp_len(b, s));
      else chk("R5 window length", n, exp_len(b, s));
      chk("R6 parity toggles", tog, exp_toggles(b));
   endtask

   initial begin
      int n;
      void'($urandom(32'd20240531));
      repeat (3) @(negedge clk);
      chk("R12 reset strobe", int'(strobe_o), 0);
      chk("R12 reset busy", int'(busy_o), 0);
      chk("R12 reset markers", int'({mark_win_o, mark_par_o}), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R12 after reset", int'({strobe_o, busy_o, mark_win_o, mark_par_o}), 0);

      // R2: phase after sync
      repeat (5) @(negedge clk);
      sync_i = 1'b1;
      @(negedge clk) sync_i = 1'b0;
      chk("R2 strobe low after sync", int'(strobe_o), 0);
      n = 1;
      while (!strobe_o) begin @(negedge clk); n++; end
      chk("R2 first strobe cycle", n, DIV);

      run_window(2, 3, 0, 0);
      run_window(3, 2, 0, 0);
      run_window(0, 4, 0, 0);
      run_window(3, 0, 0, 0);
      run_window(0, 0, 0, 0);
      run_window(7, 7, 0, 0);
      run_window(2, 2, 1, 0);
      run_window(2, 3, 0, 1);
      repeat (2 * DIV + 2) @(negedge clk);
      chk("R10 no window from ignored trigger", int'(busy_o), 0);

      // R4: trigger coincident with a strobe waits for the next strobe
      while (!strobe_o) @(negedge clk);
      cfg_b = 3'd1; cfg_s = 3'd2;
      trig_i = 1'b1;
      @(negedge clk) trig_i = 1'b0;
      chk("R4 armed not open", int'({busy_o, mark_win_o}), 2);
      n = 1;
      while (!mark_win_o) begin @(negedge clk); n++; end
      chk("R4 open cycle", n, DIV + 1);
      while (busy_o) @(negedge clk);

      // R11: sync aborts a window
      cfg_b = 3'd4; cfg_s = 3'd4;
      pulse_trig();
      repeat (3 * DIV) @(negedge clk);
      chk("R11 window running", int'(mark_win_o), 1);
      sync_i = 1'b1;
      @(negedge clk) sync_i = 1'b0;
      chk("R11 abort", int'({busy_o, mark_win_o, mark_par_o}), 0);
      n = 1;
      while (!strobe_o) begin @(negedge clk); n++; end
      chk("R11 divider restarted", n, DIV);
      repeat (2 * DIV) @(negedge clk);
      chk("R11 stays idle", int'(busy_o), 0);

      // Random mix; the model checks every cycle
      for (int it = 0; it < 40; it++) begin
         repeat ($urandom_range(0, 40)) @(negedge clk);
         if ($urandom_range(0, 5) == 0) begin
            cfg_b = BW'($urandom_range(0, 7)); cfg_s = SW'($urandom_range(0, 7));
            pulse_trig();
            repeat ($urandom_range(0, 200)) @(negedge clk);
            sync_i = 1'b1;
            @(negedge clk) sync_i = 1'b0;
            chk("R11 random abort", int'(busy_o), 0);
         end else begin
            run_window(int'($urandom_range(0, 7)), int'($urandom_range(0, 7)),
                       bit'($urandom_range(0, 1)), bit'($urandom_range(0, 1)));
         end
      end

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      wait (cyc > 190000);
      errors++;
      checks++;
      $display("FAIL watchdog act=%0d exp=%0d", cyc, 190000);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule